// File: doc/BRIEF.md
# Pad Deep-Sleep Output Controller

This block sits between the normal per-pad output path and the pads. It serves two pad groups, a muxed group and a dedicated group. Each pad has its own sleep-enable bit, a 2-bit sleep behaviour code and a sticky sleep-status bit. While a pad's status bit is clear, the pad simply carries its normal output and output-enable. When the sleep request goes from low to high, every enabled pad whose status is clear latches an override chosen by its behaviour code. The choices are drive low, drive high, float, or freeze the values driven in that cycle. The pad keeps that override until software writes a 1 to its status bit.

Dropping the sleep request does not release the override. A pad stays frozen until its status bit is cleared. Configuration is written through a simple write port. A write addresses one of three register kinds in one of the two groups.

Top module: `pad_sleep_ctrl`

## Requirements
- R1: While a pad's status bit is clear, its pad output and pad enable equal its normal output and normal enable in the same cycle.
- R2: A sleep entry is a cycle in which `sleep_req_i` is 1 and was 0 in the previous cycle. On such a cycle, a pad with enable bit 1, status clear and behaviour code 0 sets its status. From the next cycle it drives output 0 with enable 1.
- R3: With behaviour code 1, the same entry makes the pad drive output 1 with enable 1 from the next cycle.
- R4: With behaviour code 2, the same entry makes the pad float from the next cycle: output 0 and enable 0.
- R5: With behaviour code 3, the same entry makes the pad hold, from the next cycle, the normal output and enable that were present in the entry cycle.
- R6: While a pad's status is set and no clear is written, its pad output and enable do not change. This holds when the sleep request falls or rises again, when its behaviour code or enable bit is rewritten, and when the normal inputs change.
- R7: A pad whose enable bit is 0 at the entry cycle is not affected by the entry.
- R8: Writing 1 to a pad's bit in the status-clear register clears its status. From the next cycle the pad follows its normal path again. Writing 0 to a bit has no effect.
- R9: `cfg_addr_i[2]` selects the group: 0 for muxed, 1 for dedicated. `cfg_addr_i[1:0]` selects the register: 0 for enable (bit i for pad i), 1 for behaviour code (bits 2i+1:2i for pad i), 2 for status clear (bit i). Code 3 is ignored. A write affects entries from the next cycle on.
- R10: After reset all enable, behaviour and status bits are 0, so every pad follows its normal path.
- R11: The two groups are independent. Writes and status in one group never change pads of the other group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_req_i | input | 1 | Deep-sleep request level |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Register select (group in bit 2) |
| cfg_wdata_i | input | CFG_DW | Write data, 2×max(MIO_PADS, DIO_PADS) |
| mio_out_i | input | MIO_PADS | Normal output, muxed pads |
| mio_oe_i | input | MIO_PADS | Normal enable, muxed pads |
| dio_out_i | input | DIO_PADS | Normal output, dedicated pads |
| dio_oe_i | input | DIO_PADS | Normal enable, dedicated pads |
| mio_pad_out_o | output | MIO_PADS | Final output, muxed pads |
| mio_pad_oe_o | output | MIO_PADS | Final enable, muxed pads |
| dio_pad_out_o | output | DIO_PADS | Final output, dedicated pads |
| dio_pad_oe_o | output | DIO_PADS | Final enable, dedicated pads |

## Verification
The pass-through path has no register, so a pad with clear status reflects its normal inputs in the same cycle. An override shows up one cycle after the entry cycle. A status clear takes effect one cycle after the write, and a configuration write governs entries starting one cycle later. The bench drives every input on the falling edge and compares all pad outputs shortly afterwards, before the next rising edge. Its reference model advances at each rising edge with the same one-cycle latencies, so every comparison lands in the cycle where the result is due.

// File: rtl/pad_sleep_pkg.sv
package pad_sleep_pkg;

    typedef enum logic [1:0] {
        SLP_DRIVE0 = 2'd0,
        SLP_DRIVE1 = 2'd1,
        SLP_FLOAT  = 2'd2,
        SLP_FREEZE = 2'd3
    } slp_mode_e;

    localparam logic [1:0] REG_ENABLE = 2'd0;
    localparam logic [1:0] REG_MODE   = 2'd1;
    localparam logic [1:0] REG_CLEAR  = 2'd2;

    typedef struct packed {
        logic status;
        logic out;
        logic oe;
    } lane_state_t;

endpackage

// File: rtl/pad_sleep_edge.sv
module pad_sleep_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sleep_req_i,
    output logic rise_o
);
    logic req_d, req_q;

    always_comb begin
        req_d = sleep_req_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) req_q <= 1'b0;
        else         req_q <= req_d;
    end

    assign rise_o = sleep_req_i & ~req_q;

    AST_RISE_NEEDS_LOW_BEFORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o); // R2

endmodule

// File: rtl/pad_sleep_lane.sv
module pad_sleep_lane
    import pad_sleep_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      entry_i,
    input  slp_mode_e mode_i,
    input  logic      clr_i,
    input  logic      out_i,
    input  logic      oe_i,
    output logic      pad_out_o,
    output logic      pad_oe_o
);
    lane_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.status) begin
            if (clr_i) st_d.status = 1'b0;
        end else if (entry_i) begin
            st_d.status = 1'b1;
            unique case (mode_i)
                SLP_DRIVE0: begin st_d.out = 1'b0;  st_d.oe = 1'b1; end
                SLP_DRIVE1: begin st_d.out = 1'b1;  st_d.oe = 1'b1; end
                SLP_FLOAT:  begin st_d.out = 1'b0;  st_d.oe = 1'b0; end
                default:    begin st_d.out = out_i; st_d.oe = oe_i; end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pad_out_o = st_q.status ? st_q.out : out_i;
    assign pad_oe_o  = st_q.status ? st_q.oe  : oe_i;

    AST_DRIVE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (entry_i && !st_q.status && mode_i == SLP_DRIVE0) |=> (!pad_out_o && pad_oe_o)); // R2
    AST_DRIVE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (entry_i && !st_q.status && mode_i == SLP_DRIVE1) |=> (pad_out_o && pad_oe_o)); // R3
    AST_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (entry_i && !st_q.status && mode_i == SLP_FLOAT) |=> (!pad_out_o && !pad_oe_o)); // R4
    AST_FREEZE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (entry_i && !st_q.status && mode_i == SLP_FREEZE)
        |=> (pad_out_o == $past(out_i) && pad_oe_o == $past(oe_i))); // R5
    AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.status && !clr_i) |=> ($stable(pad_out_o) && $stable(pad_oe_o))); // R6
    AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.status && clr_i) |=> (pad_out_o == out_i && pad_oe_o == oe_i)); // R8

endmodule

// File: rtl/pad_sleep_group.sv
module pad_sleep_group
    import pad_sleep_pkg::*;
#(
    parameter int NPADS  = 8,
    parameter int CFG_DW = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rise_i,
    input  logic              wr_i,
    input  logic [1:0]        wr_reg_i,
    input  logic [CFG_DW-1:0] wdata_i,
    input  logic [NPADS-1:0]  out_i,
    input  logic [NPADS-1:0]  oe_i,
    output logic [NPADS-1:0]  pad_out_o,
    output logic [NPADS-1:0]  pad_oe_o
);
    localparam int MODE_W = 2 * NPADS;

    typedef struct packed {
        logic [NPADS-1:0]  en;
        logic [MODE_W-1:0] mode;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;
    logic [NPADS-1:0] clr;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i && wr_reg_i == REG_ENABLE) cfg_d.en   = wdata_i[NPADS-1:0];
        if (wr_i && wr_reg_i == REG_MODE)   cfg_d.mode = wdata_i[MODE_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign clr = (wr_i && wr_reg_i == REG_CLEAR) ? wdata_i[NPADS-1:0] : '0;

    for (genvar i = 0; i < NPADS; i++) begin : g_lane
        pad_sleep_lane i_lane (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .entry_i   (rise_i & cfg_q.en[i]),
            .mode_i    (slp_mode_e'(cfg_q.mode[2*i +: 2])),
            .clr_i     (clr[i]),
            .out_i     (out_i[i]),
            .oe_i      (oe_i[i]),
            .pad_out_o (pad_out_o[i]),
            .pad_oe_o  (pad_oe_o[i])
        );
    end

endmodule

// File: rtl/pad_sleep_ctrl.sv
module pad_sleep_ctrl
    import pad_sleep_pkg::*;
#(
    parameter int MIO_PADS = 8,
    parameter int DIO_PADS = 4,
    parameter int CFG_DW   = 2 * ((MIO_PADS > DIO_PADS) ? MIO_PADS : DIO_PADS)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                sleep_req_i,
    input  logic                cfg_we_i,
    input  logic [2:0]          cfg_addr_i,
    input  logic [CFG_DW-1:0]   cfg_wdata_i,
    input  logic [MIO_PADS-1:0] mio_out_i,
    input  logic [MIO_PADS-1:0] mio_oe_i,
    input  logic [DIO_PADS-1:0] dio_out_i,
    input  logic [DIO_PADS-1:0] dio_oe_i,
    output logic [MIO_PADS-1:0] mio_pad_out_o,
    output logic [MIO_PADS-1:0] mio_pad_oe_o,
    output logic [DIO_PADS-1:0] dio_pad_out_o,
    output logic [DIO_PADS-1:0] dio_pad_oe_o
);
    logic rise;
    logic wr_mio, wr_dio;

    assign wr_mio = cfg_we_i & ~cfg_addr_i[2];
    assign wr_dio = cfg_we_i &  cfg_addr_i[2];

    pad_sleep_edge i_edge (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sleep_req_i (sleep_req_i),
        .rise_o      (rise)
    );

    pad_sleep_group #(.NPADS(MIO_PADS), .CFG_DW(CFG_DW)) i_mio (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rise_i    (rise),
        .wr_i      (wr_mio),
        .wr_reg_i  (cfg_addr_i[1:0]),
        .wdata_i   (cfg_wdata_i),
        .out_i     (mio_out_i),
        .oe_i      (mio_oe_i),
        .pad_out_o (mio_pad_out_o),
        .pad_oe_o  (mio_pad_oe_o)
    );

    pad_sleep_group #(.NPADS(DIO_PADS), .CFG_DW(CFG_DW)) i_dio (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rise_i    (rise),
        .wr_i      (wr_dio),
        .wr_reg_i  (cfg_addr_i[1:0]),
        .wdata_i   (cfg_wdata_i),
        .out_i     (dio_out_i),
        .oe_i      (dio_oe_i),
        .pad_out_o (dio_pad_out_o),
        .pad_oe_o  (dio_pad_oe_o)
    );

endmodule

// File: tb/test_pad_sleep_ctrl.sv
module test_pad_sleep_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int MIO = 8;
    localparam int DIO = 4;
    localparam int DW  = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sleep_req = 1'b0, cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [MIO-1:0] mio_out = '0, mio_oe = '0, mio_pout, mio_poe;
    logic [DIO-1:0] dio_out = '0, dio_oe = '0, dio_pout, dio_poe;

    always #(CLK_PERIOD/2) clk = ~clk;

    pad_sleep_ctrl #(.MIO_PADS(MIO), .DIO_PADS(DIO)) i_pad_sleep_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req),
        .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
        .mio_out_i(mio_out), .mio_oe_i(mio_oe), .dio_out_i(dio_out), .dio_oe_i(dio_oe),
        .mio_pad_out_o(mio_pout), .mio_pad_oe_o(mio_poe),
        .dio_pad_out_o(dio_pout), .dio_pad_oe_o(dio_poe));

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    // reference model, indexed [group][pad]
    bit       m_en [2][MIO];
    bit [1:0] m_mode [2][MIO];
    bit       m_st [2][MIO];
    bit       m_ho [2][MIO];
    bit       m_hoe [2][MIO];
    string    m_tag [2][MIO];
    bit       m_prev;
    string    force_tag = "";

    task automatic model_reset();
        for (int g = 0; g < 2; g++)
            for (int i = 0; i < MIO; i++) begin
                m_en[g][i] = 0; m_mode[g][i] = 0; m_st[g][i] = 0;
                m_ho[g][i] = 0; m_hoe[g][i] = 0; m_tag[g][i] = "R10";
            end
        m_prev = 0;
    endtask

    // compare current outputs, then advance model across one rising edge
    task automatic step();
        #1;
        for (int g = 0; g < 2; g++) begin
            int np = g ? DIO : MIO;
            for (int i = 0; i < np; i++) begin
                bit no  = g ? dio_out[i] : mio_out[i];
                bit noe = g ? dio_oe[i]  : mio_oe[i];
                bit ao  = g ? dio_pout[i] : mio_pout[i];
                bit aoe = g ? dio_poe[i]  : mio_poe[i];
                bit eo  = m_st[g][i] ? m_ho[g][i]  : no;
                bit eoe = m_st[g][i] ? m_hoe[g][i] : noe;
                string tg = (force_tag != "") ? force_tag : m_tag[g][i];
                n_checks++;
                if (ao !== eo || aoe !== eoe) begin
                    n_fail++;
                    $display("FAIL %s group %0d pad %0d: out/oe actual %b%b expected %b%b",
                             tg, g, i, ao, aoe, eo, eoe);
                end
            end
        end
        begin
            bit rise = sleep_req && !m_prev;
            for (int g = 0; g < 2; g++) begin
                int np = g ? DIO : MIO;
                bit sel = cfg_we && (cfg_addr[2] == g[0]);
                for (int i = 0; i < np; i++) begin
                    bit no  = g ? dio_out[i] : mio_out[i];
                    bit noe = g ? dio_oe[i]  : mio_oe[i];
                    if (m_st[g][i]) begin
                        m_tag[g][i] = "R6";
                        if (sel && cfg_addr[1:0] == 2'd2 && cfg_wdata[i]) begin
                            m_st[g][i] = 0; m_tag[g][i] = "R8";
                        end
                    end else if (rise && m_en[g][i]) begin
                        m_st[g][i] = 1;
                        case (m_mode[g][i])
                            2'd0: begin m_ho[g][i] = 0;  m_hoe[g][i] = 1;   m_tag[g][i] = "R2"; end
                            2'd1: begin m_ho[g][i] = 1;  m_hoe[g][i] = 1;   m_tag[g][i] = "R3"; end
                            2'd2: begin m_ho[g][i] = 0;  m_hoe[g][i] = 0;   m_tag[g][i] = "R4"; end
                            default: begin m_ho[g][i] = no; m_hoe[g][i] = noe; m_tag[g][i] = "R5"; end
                        endcase
                    end else if (rise) m_tag[g][i] = "R7";
                    else m_tag[g][i] = "R1";
                    if (sel && cfg_addr[1:0] == 2'd0) m_en[g][i] = cfg_wdata[i];
                    if (sel && cfg_addr[1:0] == 2'd1) m_mode[g][i] = cfg_wdata[2*i +: 2];
                end
            end
            m_prev = sleep_req;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rand_data();
        mio_out = MIO'($urandom); mio_oe = MIO'($urandom);
        dio_out = DIO'($urandom); dio_oe = DIO'($urandom);
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        rand_data();
        step();
        cfg_we = 0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin rand_data(); step(); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R10: reset state, every pad follows its normal path
        force_tag = "R10"; idle(3); force_tag = "";

        // R9: muxed group, codes 0..3 across pads; dedicated enables pads 0 and 2
        wr(3'd0, 16'h00FF);
        wr(3'd1, 16'hE4E4);
        wr(3'd4, 16'h0005);
        wr(3'd5, 16'h00D8);
        // R9: address code 3 is ignored
        wr(3'd3, 16'hFFFF);
        wr(3'd7, 16'hFFFF);
        // entry: R2 R3 R4 R5 in muxed, R7 on disabled dedicated pads
        sleep_req = 1; rand_data(); step();
        idle(4);
        // R6: sleep falls, rewrites, second rise; outputs stay frozen
        sleep_req = 0; idle(2);
        wr(3'd1, 16'h1B1B);
        wr(3'd0, 16'h0000);
        sleep_req = 1; idle(3);
        // R8: zero write has no effect, then clear half of the muxed pads
        wr(3'd2, 16'h0000);
        wr(3'd2, 16'h000F);
        idle(2);
        // R11: clearing muxed pads leaves dedicated ones frozen
        force_tag = "R11"; wr(3'd2, 16'h00F0); idle(1); force_tag = "";
        // clear and entry in the same cycle: clear applies, no re-entry
        sleep_req = 0; wr(3'd0, 16'h00FF); step();
        sleep_req = 1; cfg_we = 1; cfg_addr = 3'd6; cfg_wdata = 16'h000F; rand_data(); step();
        cfg_we = 0; idle(3);

        // constrained random phase
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(7) == 0) sleep_req = ~sleep_req;
            cfg_we = ($urandom_range(3) == 0);
            cfg_addr = 3'($urandom_range(7));
            cfg_wdata = DW'($urandom);
            if (cfg_addr[1:0] == 2'd2 && $urandom_range(1) == 0) cfg_wdata = '0;
            rand_data();
            step();
        end
        cfg_we = 0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule